// File: doc/BRIEF.md
# UART Interrupt Enable and Interrupt Pin Controller

This block keeps a serial channel's interrupt enable byte and works out what each bit means for the current framing and compatibility setting. Three settings are supported: a basic setting, an enhanced setting and an alternate setting. A 9-bit framing flag sits on top of the compatibility setting. In 9-bit framing the fifth enable bit always controls the special-character interrupt. It does so whatever compatibility setting is chosen. The receiver-status bit also covers received characters whose ninth bit is set.

The masked event flags feed a fixed-priority arbiter. The arbiter registers the number of the most urgent active level, the state of the interrupt pin, and a sleep request. A sleep request is only granted while no enabled interrupt is pending. The pin output enable is either forced on by a strap input or follows the interrupt-output bit of the modem control register.

A two-flop synchroniser inside the block releases the asynchronous active-low reset in step with the clock.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is applied and after it, the enable byte is zero and `int_pin`, `irq_level` and `sleep_req` are 0. Reset takes effect without waiting for a clock edge.
- R2: With `ier_we` high, `ier_wdata` is loaded into the enable byte at the clock edge. Outputs that depend on the byte reflect it one clock later. A byte that was not written keeps its value.
- R3: Bit 0 enables receive-data (level 2), bit 1 enables transmitter-empty (level 3) and bit 3 enables modem-status (level 4). An event whose bit is clear raises nothing.
- R4: Bit 2 enables receiver-status at level 1. With `nine_bit`=1, bit 2 also lets `ev_addr_bit` raise level 1. With `nine_bit`=0, `ev_addr_bit` is ignored.
- R5: With `nine_bit`=1, bit 5 enables the special-character interrupt at level 5 and drives `spc_det_en` high.
- R6: With `nine_bit`=0 and `cmode`=1 (enhanced), bit 5 drives `spc_det_en` high and enables the level 5 special-character interrupt.
- R7: With `nine_bit`=0 and `cmode`=2 (alternate), bit 5 is a second sleep enable and `spc_det_en` stays 0. With `nine_bit`=0 and `cmode` 0 or 3, bit 5 has no effect.
- R8: `irq_level` is the smallest-numbered active enabled level, or 0 if none is active. `int_pin` is 1 exactly when `irq_level` is not 0.
- R9: `sleep_req` is 1 when bit 4 is set, or when the alternate sleep enable of R7 is set, and no enabled interrupt is pending. Otherwise it is 0.
- R10: With `int_sel_strap`=1, `int_oe` is 1 and `mcr_int_oe` is ignored. With `int_sel_strap`=0, `int_oe` equals `mcr_int_oe`.
- R11: With `nine_bit`=1, the alternate setting of `cmode` does not turn bit 5 into a sleep enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_we | input | 1 | Enable byte write strobe |
| ier_wdata | input | IER_W (6) | Enable byte write data |
| cmode | input | 2 | Compatibility setting: 0 basic, 1 enhanced, 2 alternate, 3 treated as basic |
| nine_bit | input | 1 | 9-bit framing active |
| ev_rx_status | input | 1 | Receiver status event |
| ev_addr_bit | input | 1 | Received character with ninth bit set |
| ev_rx_data | input | 1 | Receive data available event |
| ev_tx_empty | input | 1 | Transmitter empty event |
| ev_modem | input | 1 | Modem status change event |
| ev_spc_match | input | 1 | Special character matched |
| mcr_int_oe | input | 1 | Modem control interrupt-output enable bit |
| int_sel_strap | input | 1 | Strap: 1 forces the pin to drive |
| int_pin | output | 1 | Interrupt pin value |
| int_oe | output | 1 | Interrupt pin output enable |
| irq_level | output | LVL_W (3) | Highest-priority active level, 0 for none |
| sleep_req | output | 1 | Sleep request |
| spc_det_en | output | 1 | Special-character detection enable |

## Verification
The bench builds the block with its default parameters. These give a six-bit enable byte, five priority levels and a three-bit level code, so every bit of the byte and every level code can be reached. The vector table walks each combination of framing flag and compatibility setting against the fifth enable bit. It pairs competing events so that the arbiter's ordering becomes visible at `irq_level`. It also pairs pending interrupts with sleep enables to show the sleep block. Directed tests cover the one-clock write latency, reset applied mid-activity, and all four strap and output-enable pairs.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [1:0] {
    CM_BASIC    = 2'd0,
    CM_ENHANCED = 2'd1,
    CM_ALTERNATE= 2'd2,
    CM_RESERVED = 2'd3
  } cmode_e;

  // Bit positions inside the enable byte
  localparam int unsigned B_RXDATA  = 0;
  localparam int unsigned B_TXEMPTY = 1;
  localparam int unsigned B_RXSTAT  = 2;
  localparam int unsigned B_MODEM   = 3;
  localparam int unsigned B_SLEEP   = 4;
  localparam int unsigned B_SPECIAL = 5;

  localparam int unsigned IER_BITS  = 6;
  localparam int unsigned NUM_LVL   = 5;

  typedef struct packed {
    logic spc;
    logic modem;
    logic tx;
    logic data;
    logic stat;
    logic addr;
  } irq_events_t;

endpackage

// File: rtl/ier_store.sv
module ier_store #(
  parameter int unsigned IER_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IER_W-1:0] wdata,
  output logic [IER_W-1:0] ier_q
);

  logic [IER_W-1:0] ier_d;

  always_comb begin
    ier_d = ier_q;
    if (we) ier_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ier_q <= '0;
    else        ier_q <= ier_d;
  end

  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ier_q == $past(wdata)));

  assert_hold_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ier_q));

endmodule

// File: rtl/ier_decode.sv
module ier_decode
  import uart_irq_pkg::*;
#(
  parameter int unsigned IER_W   = 6,
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IER_W-1:0]   ier_q,
  input  cmode_e             cmode,
  input  logic               nine_bit,
  input  irq_events_t        ev,
  output logic [NUM_SRC-1:0] src_req,
  output logic               sleep_en,
  output logic               spc_det_en
);

  logic stat_lvl_en;
  logic addr_lvl_en;
  logic spc_lvl_en;
  logic alt_sleep;
  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] en;

  always_comb begin
    stat_lvl_en = ier_q[B_RXSTAT];
    addr_lvl_en = ier_q[B_RXSTAT] & nine_bit;
    spc_lvl_en  = 1'b0;
    alt_sleep   = 1'b0;
    spc_det_en  = 1'b0;
    if (nine_bit) begin
      spc_lvl_en = ier_q[B_SPECIAL];
      spc_det_en = ier_q[B_SPECIAL];
    end else begin
      unique case (cmode)
        CM_ENHANCED: begin
          spc_lvl_en = ier_q[B_SPECIAL];
          spc_det_en = ier_q[B_SPECIAL];
        end
        CM_ALTERNATE: alt_sleep = ier_q[B_SPECIAL];
        default: ;
      endcase
    end
    sleep_en = ier_q[B_SLEEP] | alt_sleep;
  end

  // index i corresponds to priority level i+1
  always_comb begin
    raw = '0;
    en  = '0;
    raw[0] = ev.stat | ev.addr;
    raw[1] = ev.data;
    raw[2] = ev.tx;
    raw[3] = ev.modem;
    raw[4] = ev.spc;
    en[1]  = ier_q[B_RXDATA];
    en[2]  = ier_q[B_TXEMPTY];
    en[3]  = ier_q[B_MODEM];
    en[4]  = spc_lvl_en;
    en[0]  = 1'b0;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_mask
      if (g == 0) begin : g_lvl1
        assign src_req[g] = (ev.stat & stat_lvl_en) | (ev.addr & addr_lvl_en);
      end else begin : g_lvln
        assign src_req[g] = raw[g] & en[g];
      end
    end
  endgenerate

  assert_no_spc_det_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!nine_bit && cmode != CM_ENHANCED) |-> !spc_det_en);

  assert_addr_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!nine_bit && !ev.stat) |-> !src_req[0]);

  assert_nine_no_altsleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (nine_bit && !ier_q[B_SLEEP]) |-> !sleep_en);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned LVL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               sleep_en,
  output logic [LVL_W-1:0]   lvl_q,
  output logic               any_q,
  output logic               sleep_q
);

  logic [LVL_W-1:0] lvl_d;
  logic             any_d;
  logic             sleep_d;

  always_comb begin
    lvl_d = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (src_req[i]) lvl_d = LVL_W'(i + 1);
    end
    any_d   = |src_req;
    sleep_d = sleep_en & ~any_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      any_q   <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      any_q   <= any_d;
      sleep_q <= sleep_d;
    end
  end

  assert_sleep_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |-> !any_q);

  assert_pin_matches_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_q == (lvl_q != '0));

  assert_top_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    src_req[0] |=> (lvl_q == LVL_W'(1)));

endmodule

// File: rtl/int_pin_drive.sv
module int_pin_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic any_q,
  input  logic strap,
  input  logic mcr_oe,
  output logic pin,
  output logic oe
);

  always_comb begin
    pin = any_q;
    oe  = strap | mcr_oe;
  end

  assert_strap_forces_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strap |-> oe);

  assert_mcr_controls_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strap |-> (oe == mcr_oe));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned IER_W = 6,
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_we,
  input  logic [IER_W-1:0] ier_wdata,
  input  logic [1:0]       cmode,
  input  logic             nine_bit,
  input  logic             ev_rx_status,
  input  logic             ev_addr_bit,
  input  logic             ev_rx_data,
  input  logic             ev_tx_empty,
  input  logic             ev_modem,
  input  logic             ev_spc_match,
  input  logic             mcr_int_oe,
  input  logic             int_sel_strap,
  output logic             int_pin,
  output logic             int_oe,
  output logic [LVL_W-1:0] irq_level,
  output logic             sleep_req,
  output logic             spc_det_en
);

  localparam int unsigned NUM_SRC = NUM_LVL;

  logic               rst_meta;
  logic               rst_sync_n;
  logic [IER_W-1:0]   ier_q;
  logic [NUM_SRC-1:0] src_req;
  logic               sleep_en;
  logic               any_q;
  irq_events_t        ev;
  cmode_e             cmode_t;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    cmode_t  = cmode_e'(cmode);
    ev.spc   = ev_spc_match;
    ev.modem = ev_modem;
    ev.tx    = ev_tx_empty;
    ev.data  = ev_rx_data;
    ev.stat  = ev_rx_status;
    ev.addr  = ev_addr_bit;
  end

  ier_store #(.IER_W(IER_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n & rst_sync_n),
    .we    (ier_we),
    .wdata (ier_wdata),
    .ier_q (ier_q)
  );

  ier_decode #(.IER_W(IER_W), .NUM_SRC(NUM_SRC)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n & rst_sync_n),
    .ier_q      (ier_q),
    .cmode      (cmode_t),
    .nine_bit   (nine_bit),
    .ev         (ev),
    .src_req    (src_req),
    .sleep_en   (sleep_en),
    .spc_det_en (spc_det_en)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n & rst_sync_n),
    .src_req  (src_req),
    .sleep_en (sleep_en),
    .lvl_q    (irq_level),
    .any_q    (any_q),
    .sleep_q  (sleep_req)
  );

  int_pin_drive u_pin (
    .clk    (clk),
    .rst_n  (rst_n & rst_sync_n),
    .any_q  (any_q),
    .strap  (int_sel_strap),
    .mcr_oe (mcr_int_oe),
    .pin    (int_pin),
    .oe     (int_oe)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (!int_pin && irq_level == '0 && !sleep_req));

endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  // {req[3:0], ier[5:0], nine, cmode[1:0], ev{addr,stat,data,tx,modem,spc}, lvl[2:0], pin, sleep, spc_det}
  localparam logic [24:0] VECS [NV] = '{
    {4'd3,  6'h0F, 1'b0, 2'd0, 6'b001000, 3'd2, 1'b1, 1'b0, 1'b0}, // R3 rx data
    {4'd3,  6'h0F, 1'b0, 2'd0, 6'b000110, 3'd3, 1'b1, 1'b0, 1'b0}, // R3 tx over modem
    {4'd3,  6'h08, 1'b0, 2'd0, 6'b001010, 3'd4, 1'b1, 1'b0, 1'b0}, // R3 data masked
    {4'd3,  6'h00, 1'b0, 2'd0, 6'b111111, 3'd0, 1'b0, 1'b0, 1'b0}, // R3 all masked
    {4'd4,  6'h04, 1'b0, 2'd0, 6'b100000, 3'd0, 1'b0, 1'b0, 1'b0}, // R4 addr ignored
    {4'd4,  6'h04, 1'b1, 2'd0, 6'b100000, 3'd1, 1'b1, 1'b0, 1'b0}, // R4 addr level 1
    {4'd8,  6'h07, 1'b0, 2'd0, 6'b011100, 3'd1, 1'b1, 1'b0, 1'b0}, // R8 status wins
    {4'd5,  6'h20, 1'b1, 2'd0, 6'b000001, 3'd5, 1'b1, 1'b0, 1'b1}, // R5 nine-bit special
    {4'd6,  6'h20, 1'b0, 2'd1, 6'b000001, 3'd5, 1'b1, 1'b0, 1'b1}, // R6 enhanced special
    {4'd7,  6'h20, 1'b0, 2'd0, 6'b000001, 3'd0, 1'b0, 1'b0, 1'b0}, // R7 basic: bit 5 inert
    {4'd7,  6'h20, 1'b0, 2'd2, 6'b000000, 3'd0, 1'b0, 1'b1, 1'b0}, // R7 alternate sleep
    {4'd7,  6'h20, 1'b0, 2'd2, 6'b000001, 3'd0, 1'b0, 1'b1, 1'b0}, // R7 no special irq
    {4'd11, 6'h20, 1'b1, 2'd2, 6'b000000, 3'd0, 1'b0, 1'b0, 1'b1}, // R11 nine-bit override
    {4'd9,  6'h10, 1'b0, 2'd0, 6'b000000, 3'd0, 1'b0, 1'b1, 1'b0}, // R9 sleep granted
    {4'd9,  6'h12, 1'b0, 2'd0, 6'b000100, 3'd3, 1'b1, 1'b0, 1'b0}, // R9 sleep blocked
    {4'd9,  6'h11, 1'b0, 2'd0, 6'b000100, 3'd0, 1'b0, 1'b1, 1'b0}, // R9 masked event no block
    {4'd8,  6'h3F, 1'b1, 2'd0, 6'b000011, 3'd4, 1'b1, 1'b0, 1'b1}, // R8 modem over special
    {4'd7,  6'h20, 1'b0, 2'd3, 6'b000001, 3'd0, 1'b0, 1'b0, 1'b0}  // R7 reserved as basic
  };

  logic       clk;
  logic       rst_n;
  logic       ier_we;
  logic [5:0] ier_wdata;
  logic [1:0] cmode;
  logic       nine_bit;
  logic       ev_rx_status, ev_addr_bit, ev_rx_data, ev_tx_empty, ev_modem, ev_spc_match;
  logic       mcr_int_oe, int_sel_strap;
  logic       int_pin, int_oe, sleep_req, spc_det_en;
  logic [2:0] irq_level;

  int n_checks;
  int n_fail;

  uart_irq_ctrl i_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ier_we(ier_we), .ier_wdata(ier_wdata),
    .cmode(cmode), .nine_bit(nine_bit),
    .ev_rx_status(ev_rx_status), .ev_addr_bit(ev_addr_bit), .ev_rx_data(ev_rx_data),
    .ev_tx_empty(ev_tx_empty), .ev_modem(ev_modem), .ev_spc_match(ev_spc_match),
    .mcr_int_oe(mcr_int_oe), .int_sel_strap(int_sel_strap),
    .int_pin(int_pin), .int_oe(int_oe), .irq_level(irq_level),
    .sleep_req(sleep_req), .spc_det_en(spc_det_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_events(input logic [5:0] e);
    {ev_addr_bit, ev_rx_status, ev_rx_data, ev_tx_empty, ev_modem, ev_spc_match} = e;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_checks = 0;
    n_fail = 0;
    rst_n = 1'b0;
    ier_we = 1'b0;
    ier_wdata = '0;
    cmode = 2'd0;
    nine_bit = 1'b0;
    set_events(6'b111111);
    mcr_int_oe = 1'b0;
    int_sel_strap = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset held
    check("R1 pin in reset", int_pin, 0);
    check("R1 level in reset", irq_level, 0);
    check("R1 sleep in reset", sleep_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: enable byte cleared, so events raise nothing after release
    check("R1 pin after reset", int_pin, 0);
    check("R1 level after reset", irq_level, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [24:0] t;
      t = VECS[v];
      @(negedge clk);
      ier_we = 1'b1;
      ier_wdata = t[20:15];
      nine_bit = t[14];
      cmode = t[13:12];
      set_events(t[11:6]);
      @(negedge clk);
      ier_we = 1'b0;
      @(negedge clk);
      check($sformatf("R%0d vec %0d level", t[24:21], v), irq_level, t[5:3]);
      check($sformatf("R%0d vec %0d pin", t[24:21], v), int_pin, t[2]);
      check($sformatf("R%0d vec %0d sleep", t[24:21], v), sleep_req, t[1]);
      check($sformatf("R%0d vec %0d spc_det", t[24:21], v), spc_det_en, t[0]);
    end

    // R2: write latency and hold
    @(negedge clk);
    ier_we = 1'b1; ier_wdata = 6'h00; nine_bit = 1'b0; cmode = 2'd0;
    set_events(6'b001000);
    @(negedge clk);
    ier_we = 1'b0;
    @(negedge clk);
    check("R2 pin before write", int_pin, 0);
    ier_we = 1'b1; ier_wdata = 6'h01;
    @(negedge clk);
    ier_we = 1'b0; ier_wdata = 6'h00;
    check("R2 pin one edge after write", int_pin, 0);
    @(negedge clk);
    check("R2 pin two edges after write", int_pin, 1);
    check("R2 level two edges after write", irq_level, 2);
    repeat (3) @(negedge clk);
    check("R2 value held without write", irq_level, 2);

    // R1: reset in the middle of activity clears asynchronously
    #1 rst_n = 1'b0;
    #1;
    check("R1 async reset pin", int_pin, 0);
    check("R1 async reset level", irq_level, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 byte cleared by reset", int_pin, 0);

    // R10: output enable combinations
    int_sel_strap = 1'b1; mcr_int_oe = 1'b0; #1;
    check("R10 strap high mcr low", int_oe, 1);
    mcr_int_oe = 1'b1; #1;
    check("R10 strap high mcr high", int_oe, 1);
    int_sel_strap = 1'b0; mcr_int_oe = 1'b0; #1;
    check("R10 strap low mcr low", int_oe, 0);
    mcr_int_oe = 1'b1; #1;
    check("R10 strap low mcr high", int_oe, 1);

    finish_run();
  end

endmodule